// File: doc/BRIEF.md
# I2C Slave Receiver/Transmitter with Overflow-Gated Acknowledge

This block is a 7-bit-address I2C slave that runs entirely in a fast system clock domain. It passes the bus lines through a synchroniser, detects START and STOP conditions and SCL edges, and shifts in the address byte. It compares that byte with an address the host programs. On a write it collects data bytes into a single host-visible buffer. On a read it shifts out bytes that the host loads into the same buffer.

Two host flags govern every received byte: buffer-full and overflow. Together they decide whether the byte is copied into the buffer and whether the slave pulls SDA low in the acknowledge slot. On a read, the slave holds SCL low after each acknowledged byte. It keeps the clock held until the host has supplied the next byte and set the clock-release bit. A per-byte event flag rises on the ninth falling SCL edge and stays set until the host clears it.

Top module: `i2c_ovf_slave`

## Requirements
- R1: After reset both pull-low enables are off, buffer-full, overflow, direction and event flag read 0, and the clock-release bit reads 1.
- R2: A received byte that ends while buffer-full=0 and overflow=0 is copied into the buffer and acknowledged (SDA low in the ninth clock). Buffer-full becomes 1.
- R3: A received byte that ends while buffer-full=1 and overflow=0 leaves the buffer unchanged and is not acknowledged. Overflow becomes 1.
- R4: A received byte that ends while buffer-full=1 and overflow=1 leaves the buffer and both flags unchanged and is not acknowledged.
- R5: A received byte that ends while buffer-full=0 and overflow=1 is copied into the buffer, which sets buffer-full. It is not acknowledged.
- R6: A matching address with direction bit 0 (the LSB of the address byte) clears the direction flag. The whole address byte is then treated as a received byte under the rules of R2 to R5.
- R7: A matching address with direction bit 1 sets the direction flag and is always acknowledged. From the ninth falling SCL edge the slave holds SCL low and the clock-release bit reads 0. SCL stays held until the host sets the release bit.
- R8: In a read, the buffer byte loaded by the host goes out MSB first. SDA only changes while SCL is low.
- R9: In a read, a master acknowledge (SDA low) at the ninth rising edge makes the slave hold SCL again and clear the release bit. A master not-acknowledge makes the slave release both lines and ignore the bus until the next START.
- R10: The event flag is set on the ninth falling SCL edge of every addressed byte. Only the host's clear strobe resets it; a buffer read does not.
- R11: A host buffer read clears buffer-full and leaves overflow unchanged. Only the overflow-clear strobe clears overflow.
- R12: A non-matching address is not acknowledged and raises no event. The bytes that follow, up to the next START, are neither acknowledged nor stored.
- R13: A STOP returns the slave to idle, even in the middle of a byte. Clock pulses that follow without a START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Drive SCL low when 1 |
| sda_pull | output | 1 | Drive SDA low when 1 |
| own_addr | input | 7 | Programmed 7-bit slave address |
| host_wr | input | 1 | Write strobe: load buffer and transmit shifter |
| host_wdata | input | 8 | Data for host_wr |
| host_rd | input | 1 | Read strobe: clears buffer-full |
| host_rdata | output | 8 | Current buffer contents |
| ckp_set | input | 1 | Set the clock-release bit |
| ov_clr | input | 1 | Clear the overflow flag |
| if_clr | input | 1 | Clear the event flag |
| bf | output | 1 | Buffer-full flag |
| ov | output | 1 | Overflow flag |
| rw | output | 1 | Direction of the last matched address (1 = read) |
| ckp | output | 1 | Clock-release bit (0 = SCL being held) |
| irq_flag | output | 1 | Per-byte event flag |

## Verification
The bench builds the slave with SYNC_STAGES=3 and runs an SCL quarter period of ten system clocks. This shows that the extra synchroniser latency still lets every acknowledge decision and data bit land well inside the SCL low phase. One write transaction walks all four buffer-full/overflow combinations several times in sequence, so each gating case is reached from a state the previous byte left behind. A read transaction with a held clock, a master acknowledge and a final not-acknowledge brings the stretching and bus-ignore paths within reach.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_HOLD,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } i2cs_state_e;

  typedef struct packed {
    logic take;   // copy shifter into buffer
    logic ack;    // pull SDA in the ninth clock
    logic ovf;    // raise overflow
  } rx_verdict_t;

  // Outcome for a completed received byte, from the two host flags.
  function automatic rx_verdict_t judge_rx(input logic bf, input logic ov);
    rx_verdict_t v;
    v.take = ~bf;
    v.ack  = ~bf & ~ov;
    v.ovf  = bf;
    return v;
  endfunction

  // Address byte carries the 7-bit address above the direction bit.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [ADDR_W-1:0] own);
    return rx[BYTE_W-1:1] == own;
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign rise_ev  = scl_s & ~scl_q;
  assign fall_ev  = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_hostif.sv
module i2cs_hostif
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ov_set,
  input  logic              if_set,
  input  logic              rw_set,
  input  logic              rw_clr,
  input  logic              ckp_clr,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              ckp_set,
  input  logic              ov_clr,
  input  logic              if_clr,
  output logic [BYTE_W-1:0] buf_q,
  output logic              bf_q,
  output logic              ov_q,
  output logic              rw_q,
  output logic              ckp_q,
  output logic              if_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      bf_q  <= 1'b0;
      ov_q  <= 1'b0;
      rw_q  <= 1'b0;
      ckp_q <= 1'b1;
      if_q  <= 1'b0;
    end else begin
      if (rx_load)      buf_q <= rx_byte;
      else if (host_wr) buf_q <= host_wdata;

      if (rx_load)      bf_q <= 1'b1;
      else if (host_rd) bf_q <= 1'b0;

      if (ov_set)       ov_q <= 1'b1;
      else if (ov_clr)  ov_q <= 1'b0;

      if (rw_set)       rw_q <= 1'b1;
      else if (rw_clr)  rw_q <= 1'b0;

      if (ckp_clr)      ckp_q <= 1'b0;
      else if (ckp_set) ckp_q <= 1'b1;

      if (if_set)       if_q <= 1'b1;
      else if (if_clr)  if_q <= 1'b0;
    end
  end

  // R2
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> !bf_q);

  // R3
  ovf_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_set |-> bf_q);

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              bf,
  input  logic              ov,
  input  logic              ckp,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ov_set,
  output logic              if_set,
  output logic              rw_set,
  output logic              rw_clr,
  output logic              ckp_clr,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

  i2cs_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              ack_q;
  logic              rd_q;
  logic              mack_q;

  rx_verdict_t verdict;
  logic        hit;
  logic        byte_end;
  logic        ninth_fall;

  always_comb begin
    verdict    = judge_rx(bf, ov);
    hit        = addr_hit(sh, own_addr);
    byte_end   = fall_ev && (cnt == LAST_BIT) &&
                 (state == ST_ADDR || state == ST_RX);
    ninth_fall = fall_ev && (state == ST_ADDR_ACK || state == ST_RX_ACK ||
                             state == ST_TX_ACK);
    rx_load = 1'b0;
    ov_set  = 1'b0;
    rw_set  = 1'b0;
    rw_clr  = 1'b0;
    if (byte_end) begin
      if (state == ST_RX) begin
        rx_load = verdict.take;
        ov_set  = verdict.ovf;
      end else if (hit) begin
        if (sh[0]) begin
          rw_set = 1'b1;
        end else begin
          rw_clr  = 1'b1;
          rx_load = verdict.take;
          ov_set  = verdict.ovf;
        end
      end
    end
    if_set  = ninth_fall;
    ckp_clr = ninth_fall && ((state == ST_ADDR_ACK && rd_q) ||
                             (state == ST_TX_ACK && mack_q));
  end

  assign rx_byte  = sh;
  assign scl_pull = (state == ST_TX_HOLD);
  assign sda_pull = ((state == ST_ADDR_ACK || state == ST_RX_ACK) && ack_q) ||
                    ((state == ST_TX_HOLD || state == ST_TX) && !tx_sh[BYTE_W-1]);

  // Bus sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
    end else if (start_ev) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (rise_ev && cnt != LAST_BIT) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          if (byte_end) begin
            if (state == ST_RX) begin
              ack_q <= verdict.ack;
              state <= ST_RX_ACK;
            end else if (hit) begin
              ack_q <= sh[0] ? 1'b1 : verdict.ack;
              rd_q  <= sh[0];
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (fall_ev) begin
            state <= rd_q ? ST_TX_HOLD : ST_RX;
            cnt   <= '0;
          end
        end
        ST_RX_ACK: begin
          if (fall_ev) begin
            state <= ST_RX;
            cnt   <= '0;
          end
        end
        ST_TX_HOLD: begin
          if (ckp) begin
            state <= ST_TX;
            cnt   <= '0;
          end
        end
        ST_TX: begin
          if (fall_ev) begin
            cnt <= cnt + 1'b1;
            if (cnt == TX_LAST) state <= ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (rise_ev) mack_q <= !sda_s;
          if (fall_ev) state <= mack_q ? ST_TX_HOLD : ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  // Transmit shifter: host load outside a byte, shift on falling SCL inside one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
    end else if (state == ST_TX) begin
      if (fall_ev) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
    end else if (tx_wr) begin
      tx_sh <= tx_data;
    end
  end

  // R7
  hold_sets_release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> !ckp);

  // R7
  release_needs_ckp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(ckp));

  // R8
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  // R10
  event_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_set |-> !scl_s);

endmodule

// File: rtl/i2c_ovf_slave.sv
module i2c_ovf_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              ckp_set,
  input  logic              ov_clr,
  input  logic              if_clr,
  output logic              bf,
  output logic              ov,
  output logic              rw,
  output logic              ckp,
  output logic              irq_flag
);
  logic [1:0] lines_s;
  logic scl_s, sda_s;
  logic start_ev, stop_ev, rise_ev, fall_ev;
  logic rx_load, ov_set, if_set, rw_set, rw_clr, ckp_clr;
  logic [BYTE_W-1:0] rx_byte;

  i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cs_busmon u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  i2cs_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .own_addr(own_addr),
    .bf      (bf),
    .ov      (ov),
    .ckp     (ckp),
    .tx_wr   (host_wr),
    .tx_data (host_wdata),
    .rx_load (rx_load),
    .rx_byte (rx_byte),
    .ov_set  (ov_set),
    .if_set  (if_set),
    .rw_set  (rw_set),
    .rw_clr  (rw_clr),
    .ckp_clr (ckp_clr),
    .scl_pull(scl_pull),
    .sda_pull(sda_pull)
  );

  i2cs_hostif u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .ov_set    (ov_set),
    .if_set    (if_set),
    .rw_set    (rw_set),
    .rw_clr    (rw_clr),
    .ckp_clr   (ckp_clr),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .host_rd   (host_rd),
    .ckp_set   (ckp_set),
    .ov_clr    (ov_clr),
    .if_clr    (if_clr),
    .buf_q     (host_rdata),
    .bf_q      (bf),
    .ov_q      (ov),
    .rw_q      (rw),
    .ckp_q     (ckp),
    .if_q      (irq_flag)
  );
endmodule

// File: tb/i2c_ovf_slave_tb.sv
module i2c_ovf_slave_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  wire  scl_line = scl_m & ~scl_pull;
  wire  sda_line = sda_m & ~sda_pull;

  logic       host_wr = 0, host_rd = 0, ckp_set = 0, ov_clr = 0, if_clr = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic bf, ov, rw, ckp, irq_flag;

  int checks = 0;
  int errors = 0;

  i2c_ovf_slave #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .ckp_set(ckp_set), .ov_clr(ov_clr),
    .if_clr(if_clr), .bf(bf), .ov(ov), .rw(rw), .ckp(ckp), .irq_flag(irq_flag)
  );

  // {host_rd, ov_clr, data, exp_ack, exp_bf, exp_ov, exp_buf}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0, 8'hA1},  // R2
    {1'b0, 1'b0, 8'hB2, 1'b0, 1'b1, 1'b1, 8'hA1},  // R3
    {1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1, 8'hA1},  // R4
    {1'b1, 1'b0, 8'hD4, 1'b0, 1'b1, 1'b1, 8'hD4},  // R5
    {1'b1, 1'b1, 8'hE5, 1'b1, 1'b1, 1'b0, 8'hE5},  // R2
    {1'b0, 1'b0, 8'h0F, 1'b0, 1'b1, 1'b1, 8'hE5},  // R3
    {1'b1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 8'h80},  // R2
    {1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0, 8'h01}   // R2
  };

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_q;
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_rd;
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0; @(negedge clk);
  endtask
  task automatic do_ovclr;
    ov_clr = 1'b1; @(negedge clk); ov_clr = 1'b0; @(negedge clk);
  endtask
  task automatic do_ifclr;
    if_clr = 1'b1; @(negedge clk); if_clr = 1'b0; @(negedge clk);
  endtask
  task automatic do_ckp;
    ckp_set = 1'b1; @(negedge clk); ckp_set = 1'b0; @(negedge clk);
  endtask
  task automatic do_wr(input logic [7:0] d);
    host_wdata = d; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0; @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b1; wait_q;
  endtask

  task automatic m_bit_out(input logic b);
    sda_m = b; wait_q;
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    wait_q; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic m_bit_in(output logic b);
    sda_m = 1'b1; wait_q;
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    wait_q;
    b = sda_line;
    wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic m_write_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(b);
    acked = ~b;
  endtask

  task automatic m_read_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(b);
      d[i] = b;
    end
    m_bit_out(~give_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "scl_pull", scl_pull, 0);
    chk("R1", "sda_pull", sda_pull, 0);
    chk("R1", "bf", bf, 0);
    chk("R1", "ov", ov, 0);
    chk("R1", "rw", rw, 0);
    chk("R1", "ckp", ckp, 1);
    chk("R1", "irq", irq_flag, 0);

    // R6 write address
    m_start();
    m_write_byte({OWN, 1'b0}, a);
    chk("R6", "addr ack", a, 1);
    chk("R6", "rw", rw, 0);
    chk("R6", "buf", host_rdata, {OWN, 1'b0});
    chk("R6", "bf", bf, 1);
    chk("R10", "irq after addr", irq_flag, 1);
    do_ifclr();

    // Table walk over buffer-full / overflow combinations
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][20]) do_rd();
      if (VEC[i][19]) do_ovclr();
      m_write_byte(VEC[i][18:11], a);
      chk("R2-R5 ack", $sformatf("vec%0d", i), a, VEC[i][10]);
      chk("R2-R5 bf", $sformatf("vec%0d", i), bf, VEC[i][9]);
      chk("R2-R5 ov", $sformatf("vec%0d", i), ov, VEC[i][8]);
      chk("R2-R5 buf", $sformatf("vec%0d", i), host_rdata, VEC[i][7:0]);
      chk("R10", $sformatf("irq vec%0d", i), irq_flag, 1);
      do_ifclr();
      chk("R10", $sformatf("irq cleared vec%0d", i), irq_flag, 0);
    end

    // R11 / R10: read clears BF only; OV and event flag need their own strobes
    m_write_byte(8'h77, a);
    chk("R3", "ov set", ov, 1);
    do_rd();
    chk("R11", "bf after read", bf, 0);
    chk("R11", "ov kept after read", ov, 1);
    chk("R10", "irq kept after read", irq_flag, 1);
    do_ovclr();
    chk("R11", "ov after clear", ov, 0);
    do_ifclr();
    m_stop();

    // R13 STOP mid-byte, then clocks without START
    m_start();
    m_write_byte({OWN, 1'b0}, a);
    chk("R13", "addr ack", a, 1);
    do_ifclr();
    do_rd();
    m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1); m_bit_out(1'b1);
    m_stop();
    scl_m = 1'b0; wait_q;
    m_write_byte(8'hFF, a);
    chk("R13", "no ack after stop", a, 0);
    chk("R13", "irq", irq_flag, 0);
    chk("R13", "bf", bf, 0);
    m_stop();

    // R12 address mismatch
    m_start();
    m_write_byte({OWN ^ 7'h01, 1'b0}, a);
    chk("R12", "mismatch ack", a, 0);
    chk("R12", "irq", irq_flag, 0);
    m_write_byte(8'h33, a);
    chk("R12", "data ack", a, 0);
    chk("R12", "bf", bf, 0);
    chk("R12", "buf", host_rdata, {OWN, 1'b0});
    m_stop();

    // R7 / R8 / R9 read transaction
    m_start();
    m_write_byte({OWN, 1'b1}, a);
    chk("R7", "read addr ack", a, 1);
    chk("R7", "rw", rw, 1);
    chk("R7", "scl held", scl_pull, 1);
    chk("R7", "ckp", ckp, 0);
    repeat (50) @(negedge clk);
    do_wr(8'hC6);
    chk("R7", "scl still held", scl_pull, 1);
    do_ifclr();
    do_ckp();
    repeat (3) @(negedge clk);
    chk("R7", "scl released", scl_pull, 0);
    m_read_byte(d, 1'b1);
    chk("R8", "byte0", d, 8'hC6);
    chk("R9", "held after ack", scl_pull, 1);
    chk("R9", "ckp after ack", ckp, 0);
    chk("R10", "irq read byte", irq_flag, 1);
    do_ifclr();
    do_wr(8'h3B);
    do_ckp();
    m_read_byte(d, 1'b0);
    chk("R8", "byte1", d, 8'h3B);
    chk("R9", "scl free after nack", scl_pull, 0);
    chk("R9", "sda free after nack", sda_pull, 0);
    do_ifclr();
    m_write_byte(8'h00, a);
    chk("R9", "ignored after nack", a, 0);
    chk("R9", "no irq after nack", irq_flag, 0);
    m_start();
    m_write_byte({OWN, 1'b0}, a);
    chk("R9", "new start answered", a, 1);
    m_stop();

    summary();
    $finish;
  end
endmodule